// File: doc/BRIEF.md
# Sector Load and Program Sequencer

This block is the write engine on the device side of a word-wide nonvolatile memory model. The memory is programmed one sector at a time. A sector holds 128 sixteen-bit words. The host writes single words with ordinary strobes: active-low chip enable, output enable and write enable, plus an address and a data word. The engine collects these words in a sector buffer. Once the strobes have been quiet for a programmable window, the engine rewrites the whole sector in one operation. First it erases the sector, then it stores every loaded word. Any word that was not loaded ends up all ones.

While a program operation runs, normal reads are blocked and return status instead. Bits 15 and 7 return the inverse of the same bits of the last word loaded. Bits 14 and 6 flip on every new read access. After reset, the engine refuses all loads until a start-up delay has passed. All three intervals are counted in ticks of the `tick` input, so a simulation can use short values.

The array is sized by `SECT_BITS`, which gives the number of sector-select bits kept from address bits 15..7. A full 512-sector array uses 9 bits. The default is smaller so that the model stays light. The array comes out of reset fully erased.

Top module: `sector_prog_engine`

## Requirements
- R1: After reset, `busy`, `prog_done` and `dout_en` are low, and every array word reads 16'hFFFF.
- R2: A word load needs `ce_n`=0 and `we_n`=0 while `oe_n`=1. If both enables are low while `oe_n` is 0, nothing is loaded and no program operation starts.
- R3: The load address is taken in the cycle when the later of `ce_n`/`we_n` goes low. The load data is taken in the cycle when the first of them goes high.
- R4: Address bits 6..0 pick the word inside the sector and bits 15..7 pick the sector. Words may arrive in any order.
- R5: A program operation starts once LOAD_WIN ticks pass after the last load with no new load. `busy` stays low before that point.
- R6: A program operation replaces the whole sector. Loaded words take their new value, and every other word of that sector reads 16'hFFFF, whatever it held before.
- R7: `busy` stays high for PROG_LEN ticks. `prog_done` is high for exactly one cycle, in the first cycle in which `busy` is low again.
- R8: While `busy` is high, a read returns bit 15 and bit 7 inverted from the last loaded word.
- R9: While `busy` is high, bits 14 and 6 are equal to each other, and their value alternates on each successive read access.
- R10: Loads that end within PWRUP_LEN ticks after reset are ignored.
- R11: While loading, a load to a sector other than the first load's sector is ignored when CROSS_CLOSES=0, and closes the load window (program starts) when CROSS_CLOSES=1.
- R12: Loads made while `busy` is high are ignored and do not start another program operation.
- R13: With `busy` low, a read (`ce_n`=0, `oe_n`=0, `we_n`=1) sets `dout_en` and returns the array word. `dout_en` is low in every other strobe combination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase enable for the window, program and start-up counters |
| ce_n | input | 1 | Chip enable, active low, already synchronized |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 16 | Word address: sector in 15..7, word in 6..0 |
| din | input | 16 | Write data |
| dout | output | 16 | Read data or status while busy |
| dout_en | output | 1 | High while a read access is in progress |
| busy | output | 1 | High during a program operation |
| prog_done | output | 1 | One-cycle pulse when a program operation ends |

## Verification
The program path is exercised with several load patterns:
- Words loaded in reverse order show that the word bits, not the arrival order, place each word.
- A load driven by chip enable, with the address and data changed while both enables are low, shows which edge captures each field.
- Stray loads are sent to a second sector and during the busy period. Each must leave its target erased.
- A second program of the same sector with a single word shows that old contents are wiped, not merged.

Blocked loads, one with output enable low and one sent before the start-up delay ends, must leave `busy` low through a full window.

// File: rtl/sps_pkg.sv
package sps_pkg;
  localparam int WORD_W     = 16;
  localparam int WIDX_W     = 7;
  localparam int SECT_WORDS = 1 << WIDX_W;
  localparam int SECT_FLD_W = 9;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_PROG
  } sps_state_e;
endpackage

// File: rtl/sps_strobe_decode.sv
module sps_strobe_decode
  import sps_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [15:0]       addr,
  input  logic [WORD_W-1:0] din,
  output logic              wr_act,
  output logic              load_stb,
  output logic [15:0]       load_addr,
  output logic [WORD_W-1:0] load_data,
  output logic              rd_act,
  output logic              rd_start
);
  logic wr_q, rd_q;
  logic [15:0] addr_q;

  assign wr_act    = ~ce_n & ~we_n & oe_n;
  assign rd_act    = ~ce_n & ~oe_n & we_n;
  assign rd_start  = rd_act & ~rd_q;
  // data commits when the first enable rises with output enable still high
  assign load_stb  = wr_q & (ce_n | we_n) & oe_n;
  assign load_addr = addr_q;
  assign load_data = din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (wr_act && !wr_q) addr_q <= addr;
    end
  end

  assert_commit_follows_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |-> $past(!ce_n && !we_n));
endmodule

// File: rtl/sps_load_ctrl.sv
module sps_load_ctrl
  import sps_pkg::*;
#(
  parameter int SECT_BITS    = 3,
  parameter int LOAD_WIN     = 150,
  parameter int PROG_LEN     = 10000,
  parameter int PWRUP_LEN    = 5000,
  parameter int CROSS_CLOSES = 0,
  localparam int AW_ARR = SECT_BITS + WIDX_W,
  localparam int WIN_W  = $clog2(LOAD_WIN + 1),
  localparam int PRG_W  = $clog2(PROG_LEN + 1),
  localparam int PWR_W  = $clog2(PWRUP_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_act,
  input  logic              load_stb,
  input  logic [15:0]       load_addr,
  input  logic [WORD_W-1:0] load_data,
  output logic              busy,
  output logic              prog_done,
  output logic [WORD_W-1:0] last_word,
  output logic              arr_we,
  output logic [AW_ARR-1:0] arr_waddr,
  output logic [WORD_W-1:0] arr_wdata
);
  sps_state_e state_q;
  logic [SECT_FLD_W-1:0] sect_q;
  logic [WORD_W-1:0]     buf_q [SECT_WORDS];
  logic [SECT_WORDS-1:0] mask_q;
  logic [WIN_W-1:0]      win_cnt;
  logic [PRG_W-1:0]      prg_cnt;
  logic [PWR_W-1:0]      pwr_cnt;
  logic [WIDX_W-1:0]     sweep_idx;
  logic                  sweep_run;

  logic pwr_ok, same_sect, accept, cross_hit, win_end, prog_end;
  logic [WIDX_W-1:0] widx;

  assign widx      = load_addr[WIDX_W-1:0];
  assign pwr_ok    = (pwr_cnt == PWR_W'(PWRUP_LEN));
  assign same_sect = (load_addr[15:WIDX_W] == sect_q);
  assign accept    = load_stb & pwr_ok &
                     ((state_q == ST_IDLE) | ((state_q == ST_LOAD) & same_sect));
  assign cross_hit = load_stb & pwr_ok & (state_q == ST_LOAD) & ~same_sect;
  assign win_end   = tick & (win_cnt == WIN_W'(LOAD_WIN - 1));
  assign prog_end  = (prg_cnt == PRG_W'(PROG_LEN)) & ~sweep_run;

  assign busy      = (state_q == ST_PROG);
  assign arr_we    = busy & sweep_run;
  assign arr_waddr = {sect_q[SECT_BITS-1:0], sweep_idx};
  assign arr_wdata = mask_q[sweep_idx] ? buf_q[sweep_idx] : {WORD_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_cnt <= '0;
    else if (tick && !pwr_ok) pwr_cnt <= pwr_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (accept) buf_q[widx] <= load_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sect_q    <= '0;
      mask_q    <= '0;
      win_cnt   <= '0;
      prg_cnt   <= '0;
      sweep_idx <= '0;
      sweep_run <= 1'b0;
      prog_done <= 1'b0;
      last_word <= '0;
    end else begin
      prog_done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q      <= ST_LOAD;
            sect_q       <= load_addr[15:WIDX_W];
            mask_q[widx] <= 1'b1;
            last_word    <= load_data;
            win_cnt      <= '0;
          end
        end
        ST_LOAD: begin
          if (accept) begin
            mask_q[widx] <= 1'b1;
            last_word    <= load_data;
            win_cnt      <= '0;
          end else if ((cross_hit && CROSS_CLOSES != 0) || (!wr_act && win_end)) begin
            state_q   <= ST_PROG;
            prg_cnt   <= '0;
            sweep_idx <= '0;
            sweep_run <= 1'b1;
          end else if (wr_act) begin
            win_cnt <= '0;
          end else if (tick) begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (sweep_run) begin
            sweep_idx <= sweep_idx + 1'b1;
            if (sweep_idx == '1) sweep_run <= 1'b0;
          end
          if (tick && prg_cnt != PRG_W'(PROG_LEN)) prg_cnt <= prg_cnt + 1'b1;
          if (prog_end) begin
            state_q   <= ST_IDLE;
            prog_done <= 1'b1;
            mask_q    <= '0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_end_pulses_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(state_q == ST_PROG) |-> prog_done);
  assert_done_only_after_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |-> $past(state_q == ST_PROG));
  assert_no_load_before_pwrup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> pwr_ok);
endmodule

// File: rtl/sps_array.sv
module sps_array
  import sps_pkg::*;
#(
  parameter int SECT_BITS = 3,
  localparam int AW    = SECT_BITS + WIDX_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= {WORD_W{1'b1}};
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sector_prog_engine.sv
module sector_prog_engine
  import sps_pkg::*;
#(
  parameter int SECT_BITS    = 3,
  parameter int LOAD_WIN     = 150,
  parameter int PROG_LEN     = 10000,
  parameter int PWRUP_LEN    = 5000,
  parameter int CROSS_CLOSES = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [15:0] addr,
  input  logic [15:0] din,
  output logic [15:0] dout,
  output logic        dout_en,
  output logic        busy,
  output logic        prog_done
);
  localparam int AW_ARR = SECT_BITS + WIDX_W;

  logic              wr_act, load_stb, rd_act, rd_start, arr_we, tog_q;
  logic [15:0]       load_addr;
  logic [WORD_W-1:0] load_data, last_word, arr_wdata, arr_rdata, poll_word;
  logic [AW_ARR-1:0] arr_waddr, arr_raddr;

  sps_strobe_decode u_dec (
    .clk, .rst_n, .ce_n, .oe_n, .we_n, .addr, .din,
    .wr_act, .load_stb, .load_addr, .load_data, .rd_act, .rd_start
  );

  sps_load_ctrl #(
    .SECT_BITS(SECT_BITS), .LOAD_WIN(LOAD_WIN), .PROG_LEN(PROG_LEN),
    .PWRUP_LEN(PWRUP_LEN), .CROSS_CLOSES(CROSS_CLOSES)
  ) u_ctrl (
    .clk, .rst_n, .tick, .wr_act, .load_stb, .load_addr, .load_data,
    .busy, .prog_done, .last_word, .arr_we, .arr_waddr, .arr_wdata
  );

  assign arr_raddr = {addr[WIDX_W+SECT_BITS-1:WIDX_W], addr[WIDX_W-1:0]};

  sps_array #(.SECT_BITS(SECT_BITS)) u_arr (
    .clk, .rst_n, .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(arr_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else if (busy && rd_start) tog_q <= ~tog_q;
  end

  always_comb begin
    poll_word     = last_word;
    poll_word[15] = ~last_word[15];
    poll_word[7]  = ~last_word[7];
    poll_word[14] = tog_q;
    poll_word[6]  = tog_q;
  end

  assign dout    = busy ? poll_word : arr_rdata;
  assign dout_en = rd_act;
endmodule

// File: tb/sector_prog_engine_bench.sv
module sector_prog_engine_bench;
  localparam int WIN = 40;
  localparam int PRG = 300;
  localparam int PWR = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0, din = '0;
  logic [15:0] dout;
  logic dout_en, busy, prog_done;

  int total = 0, fails = 0, cyc = 0;
  int t_rise = -1, t_fall = -1;
  bit done_at_fall = 0, done_after = 0, busy_prev = 0, fall_seen = 0;

  always #10 clk = ~clk;

  sector_prog_engine #(
    .SECT_BITS(3), .LOAD_WIN(WIN), .PROG_LEN(PRG), .PWRUP_LEN(PWR), .CROSS_CLOSES(0)
  ) u_sector_prog_engine (
    .clk, .rst_n, .tick(1'b1), .ce_n, .oe_n, .we_n, .addr, .din,
    .dout, .dout_en, .busy, .prog_done
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (fall_seen) begin done_after <= prog_done; fall_seen <= 0; end
    if (busy && !busy_prev) t_rise <= cyc;
    if (!busy && busy_prev) begin t_fall <= cyc; done_at_fall <= prog_done; fall_seen <= 1; end
    busy_prev <= busy;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 0; we_n = 0;
    @(negedge clk);
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic read_word(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    @(negedge clk); d = dout;
    oe_n = 1; ce_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    @(negedge clk);
    chk(busy == 0, "R1 busy", 32'(busy), 0);
    chk(prog_done == 0, "R1 prog_done", 32'(prog_done), 0);
    chk(dout_en == 0, "R1 dout_en", 32'(dout_en), 0);
  endtask

  task automatic t_pwrup();
    logic [15:0] d;
    write_word(16'h0105, 16'h1234);
    repeat (WIN + 20) @(negedge clk);
    chk(busy == 0, "R10 no program", 32'(busy), 0);
    read_word(16'h0105, d);
    chk(d == 16'hFFFF, "R10 word untouched / R1 erased", 32'(d), 32'hFFFF);
  endtask

  task automatic t_oe_block();
    @(negedge clk); addr = 16'h0203; din = 16'h5555; ce_n = 0; oe_n = 0; we_n = 0;
    repeat (3) @(negedge clk);
    chk(dout_en == 0, "R13 no dout_en with we low", 32'(dout_en), 0);
    we_n = 1; ce_n = 1;
    @(negedge clk); oe_n = 1;
    repeat (WIN + 20) @(negedge clk);
    chk(busy == 0, "R2 oe low blocks load", 32'(busy), 0);
  endtask

  task automatic t_program();
    logic [15:0] r1, r2, d;
    write_word(16'h0105, 16'hA5A5);
    // R3: chip-enable driven load, address/data change while both enables low
    @(negedge clk); addr = 16'h0109; din = 16'hDEAD; ce_n = 1; we_n = 0;
    @(negedge clk); ce_n = 0;
    @(negedge clk); addr = 16'h010A; din = 16'hBEEF;
    @(negedge clk); ce_n = 1;
    @(negedge clk); we_n = 1;
    write_word(16'h0201, 16'h7777);
    write_word(16'h0100, 16'h0F0F);
    write_word(16'h017F, 16'h1357);
    repeat (WIN - 10) @(negedge clk);
    chk(busy == 0, "R5 still loading", 32'(busy), 0);
    repeat (20) @(negedge clk);
    chk(busy == 1, "R5 program started", 32'(busy), 1);
    read_word(16'h0105, r1);
    read_word(16'h0105, r2);
    chk(r1[15] == 1'b1 && r1[7] == 1'b1, "R8 inverted bits", 32'({r1[15], r1[7]}), 32'h3);
    chk(r1[6] == r1[14] && r2[6] == r2[14], "R9 toggle pair equal", 32'({r1[14], r1[6], r2[14], r2[6]}), 32'h0);
    chk(r1[6] != r2[6], "R9 toggle alternates", 32'(r2[6]), 32'(~r1[6]));
    write_word(16'h0101, 16'h4444);
    wait_idle();
    chk((t_fall - t_rise) >= PRG && (t_fall - t_rise) <= PRG + 2, "R7 busy length",
        32'(t_fall - t_rise), 32'(PRG + 1));
    chk(done_at_fall == 1 && done_after == 0, "R7 done pulse", 32'({done_at_fall, done_after}), 32'h2);
    repeat (WIN + 20) @(negedge clk);
    chk(busy == 0, "R12 no second program", 32'(busy), 0);
    read_word(16'h0105, d); chk(d == 16'hA5A5, "R4 word 5", 32'(d), 32'hA5A5);
    chk(dout_en == 0, "R13 dout_en low after read", 32'(dout_en), 0);
    read_word(16'h0100, d); chk(d == 16'h0F0F, "R4 word 0 / R13 read", 32'(d), 32'h0F0F);
    read_word(16'h017F, d); chk(d == 16'h1357, "R4 word 127", 32'(d), 32'h1357);
    read_word(16'h0109, d); chk(d == 16'hBEEF, "R3 captured fields", 32'(d), 32'hBEEF);
    read_word(16'h010A, d); chk(d == 16'hFFFF, "R3 late address not used", 32'(d), 32'hFFFF);
    read_word(16'h0101, d); chk(d == 16'hFFFF, "R12 busy load ignored", 32'(d), 32'hFFFF);
    read_word(16'h0132, d); chk(d == 16'hFFFF, "R6 unloaded erased", 32'(d), 32'hFFFF);
    read_word(16'h0201, d); chk(d == 16'hFFFF, "R11 foreign sector ignored", 32'(d), 32'hFFFF);
  endtask

  task automatic t_rewrite();
    logic [15:0] d;
    write_word(16'h0132, 16'h2222);
    repeat (WIN + 10) @(negedge clk);
    wait_idle();
    read_word(16'h0105, d); chk(d == 16'hFFFF, "R6 old word erased", 32'(d), 32'hFFFF);
    read_word(16'h0132, d); chk(d == 16'h2222, "R6 new word stored", 32'(d), 32'h2222);
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_pwrup();
        t_oe_block();
        t_program();
        t_rewrite();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    join
  end
endmodule